// File: doc/BRIEF.md
# Modulo Timer PWM Channel

This block is a free-running up-counter that restarts from zero after it reaches a programmable limit. A clock divider sits in front of it and selects how many bus clocks make one counter tick. One output-compare channel watches the counter and shapes a pulse-width-modulated waveform. The limit sets the waveform period and the compare value sets the pulse width in counter ticks. The output is forced active each time the counter wraps and forced inactive when the count reaches the compare value. Because the output is set at both ends of the pulse, it corrects itself every period, and a compare value of zero gives a true 0% duty cycle.

Software writes the control, limit, compare and flag registers through a simple single-cycle write port. The compare register has no shadow copy, so a new value is used on the very next counter tick. Two status flags mark the end of each pulse and the end of each period. Each flag can raise its own interrupt line. Software can use these events to time its compare updates: a shorter pulse is written after the compare event, and a longer pulse is written after the wrap event.

Register map (2-bit address): 0 = control, 1 = limit, 2 = compare, 3 = flags. In the control register, bits [2:0] are the divider select, bit 3 is the output polarity, bit 4 is the compare interrupt enable and bit 5 is the wrap interrupt enable.

Top module: `modtimer_pwm`

## Requirements
- R1: With the divider at 1, the counter steps 0,1,...,LIMIT and then returns to 0, so one period lasts LIMIT+1 ticks. A limit of 255 gives a 256-clock period.
- R2: Control bits [2:0] = s select a tick every 2^s bus clocks for s from 0 to 6. Select value 7 also gives divide-by-64. The period is then (LIMIT+1)*2^s clocks.
- R3: For a compare value C with 1 <= C <= LIMIT, the output is active for the first C ticks of every period; C=128 with LIMIT=255 gives 50%. C=0 keeps the output inactive all the time, and C>LIMIT keeps it active all the time.
- R4: The output goes active at the wrap and inactive at the compare; it never toggles. A period that was disturbed therefore comes back to the programmed width in the next period.
- R5: A compare write (address 2) takes effect on the next tick. Suppose the count has not yet reached the old value and the new value is already below the count. Then no compare event occurs in that period, and the output stays active until the wrap.
- R6: Suppose the compare has already occurred and a larger value is then written. A second compare event occurs in the same period, and the output stays inactive.
- R7: Flag bit 0 is set by each compare event and flag bit 1 by each wrap. Writing 1 to a flag bit at address 3 clears it. If an event and a clear fall in the same cycle, the flag ends up set.
- R8: irq_cmp equals the compare flag ANDed with control bit 4. irq_ovf equals the wrap flag ANDed with control bit 5.
- R9: When control bit 3 is 1, the output is active-low (pwm_out is inverted). When it is 0, the output is active-high.
- R10: A write to the limit register (address 1) clears the counter and the divider on that clock edge. Counting then restarts from 0 with a full divider interval.
- R11: After reset, the counter is 0, the limit is all ones, the compare value and the control register are 0, both flags are clear, and pwm_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | PWM waveform, polarity applied |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Wrap interrupt request |
| cmp_flag | output | 1 | Compare status flag |
| ovf_flag | output | 1 | Wrap status flag |
| count | output | CNT_W | Current counter value |

## Verification
The hardest cases to reach are the unsynchronised compare updates. One is a write that lands below the count before the old compare was reached. The other is a larger value written after the compare has already fired. Both depend on the exact cycle of the write relative to the counter. The bench waits on the count output until it reaches a chosen value, then issues the write at that edge. It then follows the output and the compare flag until the wrap, and through the following period, to see both the skipped or doubled compare and the self-correction. The same count-aligned write is used to land a flag clear on the very edge of a wrap.

// File: rtl/mtp_pkg.sv
// Package: shared register addresses and the control register layout
// for the modulo timer PWM channel.
package mtp_pkg;

    // Register select values on the write port
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_LIMIT = 2'd1,
        REG_MATCH = 2'd2,
        REG_FLAGS = 2'd3
    } reg_addr_e;

    // Control register, LSB first: psel[2:0], active_low, cmp_ie, ovf_ie
    typedef struct packed {
        logic       ovf_ie;
        logic       cmp_ie;
        logic       active_low;
        logic [2:0] psel;
    } ctrl_t;

    localparam int CTRL_W       = 6;
    localparam int FLAG_CMP_BIT = 0;
    localparam int FLAG_OVF_BIT = 1;

endpackage

// File: rtl/mtp_prescaler.sv
// Module: mtp_prescaler
// Divides the bus clock into counter ticks. Select value s gives a tick
// every 2^s clocks; values above MAX_LOG saturate at 2^MAX_LOG.
// Assumes: restart clears the divider, so the first tick after a restart
// comes a full interval later.
module mtp_prescaler #(
    parameter int MAX_LOG = 6,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [MAX_LOG-1:0] div_q;
    logic [MAX_LOG-1:0] mask;

    // Build the mask of divider bits that must all be one for a tick
    for (genvar i = 0; i < MAX_LOG; i++) begin : g_mask
        assign mask[i] = (sel > SEL_W'(i));
    end

    assign tick = &(div_q | ~mask);

    // Free-running divider, cleared by reset or restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    // R2: with any division above 1, two ticks never fall back to back
    assert_no_double_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mask[0]) |=> (!tick || mask != $past(mask)));

endmodule

// File: rtl/mtp_counter.sv
// Module: mtp_counter
// Modulo up-counter: counts 0..limit on each step, then wraps to 0.
// Exposes the value it will load on the next step, so that the channel
// can compare without a cycle of lag.
// Assumes: a limit write always comes with restart, so the count never
// exceeds the limit.
module mtp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             step,
    output logic             wrap
);

    logic at_lim;

    // Next-value logic and the step and wrap qualifiers
    always_comb begin
        step    = tick && !restart;
        at_lim  = (cnt_q == limit);
        wrap    = step && at_lim;
        cnt_nxt = at_lim ? '0 : cnt_q + 1'b1;
    end

    // Count register: a restart clears it, a step advances it
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (step)         cnt_q <= cnt_nxt;
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
    assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
    assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/mtp_channel.sv
// Module: mtp_channel
// Output-compare channel in PWM mode. The output is set active at the
// wrap and cleared when the count steps onto the compare value; when both
// happen on the same edge, the clear wins (0% duty).
// Assumes: the compare value is unbuffered and used as it stands.
module mtp_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] match,
    input  logic             active_low,
    output logic             cmp_evt,
    output logic             pwm_out
);

    logic active_q;

    // Compare fires when the count steps onto the compare value
    assign cmp_evt = step && (cnt_nxt == match);

    // Level register: a compare forces it inactive, a wrap forces it active
    always_ff @(posedge clk) begin
        if (!rst_n)       active_q <= 1'b0;
        else if (cmp_evt) active_q <= 1'b0;
        else if (wrap)    active_q <= 1'b1;
    end

    // Polarity applied at the pin
    assign pwm_out = active_q ^ active_low;

    assert_cmp_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> !active_q);
    assert_wrap_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cmp_evt) |=> active_q);
    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(active_q));

endmodule

// File: rtl/mtp_regs.sv
// Module: mtp_regs
// Write-only register file: control, limit and compare registers, plus
// the two sticky status flags with write-one-to-clear.
// Assumes: when a flag event and its clear fall in one cycle, the event wins.
module mtp_regs #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              cmp_evt,
    input  logic              ovf_evt,
    output mtp_pkg::ctrl_t    ctrl,
    output logic [CNT_W-1:0]  limit,
    output logic [CNT_W-1:0]  match,
    output logic              limit_wr,
    output logic              cmp_flag,
    output logic              ovf_flag
);
    import mtp_pkg::*;

    reg_addr_e addr;
    logic      clr_cmp;
    logic      clr_ovf;

    // Address decode and write-one-to-clear strobes
    always_comb begin
        addr     = reg_addr_e'(wr_addr);
        limit_wr = wr_en && (addr == REG_LIMIT);
        clr_cmp  = wr_en && (addr == REG_FLAGS) && wr_data[FLAG_CMP_BIT];
        clr_ovf  = wr_en && (addr == REG_FLAGS) && wr_data[FLAG_OVF_BIT];
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            limit <= '1;
            match <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_CTRL:  ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
                REG_LIMIT: limit <= wr_data;
                REG_MATCH: match <= wr_data;
                default:   ;
            endcase
        end
    end

    // Sticky flags: an event sets the flag, a clear strobe drops it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            cmp_flag <= cmp_evt || (cmp_flag && !clr_cmp);
            ovf_flag <= ovf_evt || (ovf_flag && !clr_ovf);
        end
    end

    assert_cmp_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> cmp_flag);
    assert_ovf_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
    assert_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !ovf_evt) |=> !ovf_flag);

endmodule

// File: rtl/modtimer_pwm.sv
// Module: modtimer_pwm (top)
// Modulo timer with clock divider and a single PWM output-compare channel.
// Assumes: single-cycle register writes; no readback path.
module modtimer_pwm #(
    parameter int CNT_W   = 16,
    parameter int MAX_LOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             irq_cmp,
    output logic             irq_ovf,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] count
);
    import mtp_pkg::*;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] match;
    logic [CNT_W-1:0] cnt_nxt;
    logic             limit_wr;
    logic             tick;
    logic             step;
    logic             wrap;
    logic             cmp_evt;

    mtp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_evt(cmp_evt), .ovf_evt(wrap),
        .ctrl(ctrl), .limit(limit), .match(match), .limit_wr(limit_wr),
        .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
    );

    mtp_prescaler #(.MAX_LOG(MAX_LOG), .SEL_W(3)) u_psc (
        .clk(clk), .rst_n(rst_n), .restart(limit_wr), .sel(ctrl.psel),
        .tick(tick)
    );

    mtp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(limit_wr),
        .limit(limit), .cnt_q(count), .cnt_nxt(cnt_nxt), .step(step),
        .wrap(wrap)
    );

    mtp_channel #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .step(step), .wrap(wrap),
        .cnt_nxt(cnt_nxt), .match(match), .active_low(ctrl.active_low),
        .cmp_evt(cmp_evt), .pwm_out(pwm_out)
    );

    // Interrupt requests gated by their enables
    assign irq_cmp = cmp_flag && ctrl.cmp_ie;
    assign irq_ovf = ovf_flag && ctrl.ovf_ie;

endmodule

// File: tb/modtimer_pwm_bench.sv
`timescale 1ns/1ps
module modtimer_pwm_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_out, irq_cmp, irq_ovf, cmp_flag, ovf_flag;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit pol_l  = 0;

    modtimer_pwm #(.CNT_W(CNT_W)) u_modtimer_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .irq_cmp(irq_cmp),
        .irq_ovf(irq_ovf), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
        .count(count)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input int psel, input bit pol, input bit cie, input bit oie);
        pol_l = pol;
        wr(2'd0, {oie, cie, pol, 3'(psel)});
    endtask

    task automatic wait_count(input int v);
        while (count != CNT_W'(v)) @(negedge clk);
    endtask

    // Measure one full period from wrap to wrap: cycles and active cycles
    task automatic measure(output int per, output int act);
        logic [CNT_W-1:0] prev;
        prev = count;
        @(negedge clk);
        while (!(count == 0 && prev != 0)) begin prev = count; @(negedge clk); end
        per = 0; act = 0;
        do begin
            if (pwm_out ^ pol_l) act++;
            per++;
            prev = count;
            @(negedge clk);
        end while (!(count == 0 && prev != 0));
    endtask

    task automatic setup(input int psel, input int lim, input int cmpv);
        int p, a;
        set_ctrl(psel, pol_l, 0, 0);
        wr(2'd2, cmpv);
        wr(2'd1, lim);
        measure(p, a);
    endtask

    task automatic t_reset;
        chk(count == 0, "R11 count", count, 0);
        chk(pwm_out == 0, "R11 pwm_out", pwm_out, 0);
        chk(!cmp_flag && !ovf_flag, "R11 flags", {cmp_flag, ovf_flag}, 0);
        repeat (5) @(negedge clk);
        chk(count == 5, "R11 limit all ones, counting", count, 5);
        chk(pwm_out == 0, "R11 cmp zero keeps output low", pwm_out, 0);
    endtask

    task automatic t_basic;
        int p, a;
        setup(0, 255, 128);
        measure(p, a);
        chk(p == 256, "R1 period 256", p, 256);
        chk(a == 128, "R3 50% duty", a, 128);
        setup(0, 9, 3);
        measure(p, a);
        chk(p == 10, "R1 period 10", p, 10);
        chk(a == 3, "R3 width 3", a, 3);
    endtask

    task automatic t_edges;
        int p, a;
        setup(0, 9, 0);
        measure(p, a);
        chk(a == 0, "R3 zero duty", a, 0);
        setup(0, 9, 10);
        measure(p, a);
        chk(a == 10, "R3 full duty", a, 10);
        setup(0, 9, 9);
        measure(p, a);
        chk(a == 9, "R3 cmp equals limit", a, 9);
    endtask

    task automatic t_prescale;
        int p, a;
        setup(2, 9, 4);
        measure(p, a);
        chk(p == 40, "R2 div4 period", p, 40);
        chk(a == 16, "R2 div4 width", a, 16);
        setup(7, 3, 1);
        measure(p, a);
        chk(p == 256, "R2 sel7 is div64", p, 256);
        chk(a == 64, "R2 sel7 width", a, 64);
    endtask

    task automatic t_polarity;
        int p, a;
        pol_l = 1;
        setup(0, 9, 3);
        measure(p, a);
        chk(a == 3, "R9 active-low width", a, 3);
        wait_count(1);
        chk(pwm_out == 0, "R9 active level is low", pwm_out, 0);
        wait_count(5);
        chk(pwm_out == 1, "R9 idle level is high", pwm_out, 1);
        pol_l = 0;
        set_ctrl(0, 0, 0, 0);
    endtask

    task automatic t_skip;
        int p, a, n;
        setup(0, 99, 80);
        wait_count(50);
        wr(2'd2, 20);
        wr(2'd3, 3);
        n = 0; a = 0;
        while (count != 0) begin if (pwm_out) a++; n++; @(negedge clk); end
        chk(a == n && n == 48, "R5 skipped compare stays active", a, 48);
        chk(cmp_flag == 0, "R5 no compare event", cmp_flag, 0);
        chk(ovf_flag == 1, "R7 wrap flag set", ovf_flag, 1);
        measure(p, a);
        chk(a == 20, "R4 self-corrects next period", a, 20);
    endtask

    task automatic t_double;
        setup(0, 99, 20);
        wait_count(30);
        wr(2'd3, 1);
        wr(2'd2, 60);
        chk(cmp_flag == 0, "R6 flag cleared", cmp_flag, 0);
        wait_count(59);
        chk(cmp_flag == 0, "R6 no event before new value", cmp_flag, 0);
        @(negedge clk);
        chk(cmp_flag == 1, "R6 second compare", cmp_flag, 1);
        chk(pwm_out == 0, "R6 output stays inactive", pwm_out, 0);
    endtask

    task automatic t_flags;
        setup(0, 9, 4);
        set_ctrl(0, 0, 1, 0);
        wait_count(9);
        wr(2'd3, 2);
        chk(ovf_flag == 1, "R7 event wins over clear", ovf_flag, 1);
        wait_count(2);
        wr(2'd3, 2);
        chk(ovf_flag == 0, "R7 write-one clears", ovf_flag, 0);
        wait_count(5);
        chk(irq_cmp == 1, "R8 cmp irq enabled", irq_cmp, 1);
        wait_count(1);
        chk(ovf_flag == 1 && irq_ovf == 0, "R8 ovf irq masked", irq_ovf, 0);
        set_ctrl(0, 0, 0, 1);
        chk(irq_ovf == 1 && irq_cmp == 0, "R8 enables swapped", {irq_ovf, irq_cmp}, 2);
    endtask

    task automatic t_limit_write;
        int z;
        setup(2, 99, 50);
        wait_count(50);
        wr(2'd1, 99);
        z = 0;
        while (count == 0 && z < 10) begin z++; @(negedge clk); end
        chk(z == 4, "R10 counter and divider restart", z, 4);
        chk(count == 1, "R10 count resumes", count, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_edges();
        t_prescale();
        t_polarity();
        t_skip();
        t_double();
        t_flags();
        t_limit_write();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule